// File: doc/BRIEF.md
# Die-Wide Garbage Collection Sequencer

This block reclaims space on one flash die by treating the blocks that share an index in every plane as a single victim group. When it gets a start pulse, it picks the group that holds the fewest valid pages in total. It then copies out that group's valid pages in lock-step pairs: one die-wide read followed by one die-wide write. Every plane's destination offset therefore moves forward together, and the write points stay aligned once collection ends. It finishes with one erase that covers the whole group.

The valid-page bitmap of the die is an input. It is held stable while the block is busy. The output is a single command channel with a valid/ready handshake. Each command carries an opcode, the group index, one page field per plane and one slot-enable bit per plane. When a plane runs out of valid pages before the others, its slot in the remaining pairs is left empty. Its destination offset still advances with the rest.

Top module: `gc_die_seq`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `cmd_valid_o` are low. No command is offered while `busy_o` is low.
- R2: Bit `(p*NBLK + b)*NPAGES + g` of `valid_map_i` marks page g of block b in plane p as valid. The victim is the block index b with the smallest number of valid pages summed over all planes. Among equal sums, the lowest index wins.
- R3: Commands use the opcode 0 for read, 1 for write and 2 for erase. A collection issues read/write pairs, each read directly followed by its write, and then exactly one erase as the final command.
- R4: In the k-th read, plane p's slot (page field at bits `[p*PG_W +: PG_W]`, enable at mask bit p) holds the k-th valid page of the victim in plane p, in ascending page order. If that plane has no k-th valid page, the enable bit is 0 and the page field is 0.
- R5: The k-th write carries the same mask as its read. Every plane's page field holds the destination offset k, which starts at 0 for each collection.
- R6: The number of read/write pairs equals the largest per-plane valid count of the victim. A victim with no valid pages goes straight to the erase.
- R7: The erase carries the victim index in `cmd_blk_o`, all mask bits set and all page fields 0.
- R8: A command that is offered but not accepted stays offered with all of its fields unchanged.
- R9: `busy_o` is high from the cycle after `start_i` is accepted until the erase is accepted. `done_o` is a one-cycle pulse in the cycle after the erase is accepted, with `busy_o` low.
- R10: A `start_i` pulse that arrives while busy has no effect. The command sequence is unchanged, and no further collection follows the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Starts a collection when idle |
| valid_map_i | input | NPLANES*NBLK*NPAGES | Valid-page bitmap of the die |
| busy_o | output | 1 | Collection in progress |
| done_o | output | 1 | One-cycle completion pulse |
| cmd_valid_o | output | 1 | Command offered |
| cmd_ready_i | input | 1 | Command accepted |
| cmd_op_o | output | 2 | 0 read, 1 write, 2 erase |
| cmd_blk_o | output | $clog2(NBLK) | Victim block index |
| cmd_page_o | output | NPLANES*$clog2(NPAGES) | Per-plane page or destination offset |
| cmd_mask_o | output | NPLANES | Per-plane slot enable |

## Verification
A wrong victim register shows up on the block field of the very first command, so it is visible within two cycles of start. A scan cursor that advances wrongly, or a destination counter that slips, corrupts the page fields of the next read or write in the same pair sequence. A state machine that loses its place appears as a write without its read, a missing or second erase, or a done pulse that is late or never comes. The bench stalls the ready line at random so that each of these faults has to survive back-pressure.

// File: rtl/gc_pkg.sv
// Shared types for the die-wide garbage collection sequencer.
// Assumes opcode encodings are fixed by the command consumer.
package gc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_SELECT, ST_READ, ST_WRITE, ST_ERASE, ST_DONE
    } gc_state_e;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_ERASE = 2'd2
    } gc_op_e;
endpackage

// File: rtl/gc_victim_pick.sv
// Greedy victim picker: sums valid pages of each block index over all
// planes and returns the index with the smallest sum (lowest on ties).
// Assumes NBLK >= 2. Purely combinational.
module gc_victim_pick #(
    parameter int NPLANES = 2,
    parameter int NBLK    = 4,
    parameter int NPAGES  = 8
) (
    input  logic [NPLANES*NBLK*NPAGES-1:0] map_i,
    output logic [$clog2(NBLK)-1:0]        blk_o
);
    localparam int BLK_W = $clog2(NBLK);
    localparam int SUM_W = $clog2(NPLANES*NPAGES+1);

    logic [SUM_W-1:0] sum, best;

    // Scan block indices in ascending order, keep strict minimum.
    always_comb begin
        blk_o = '0;
        best  = '0;
        sum   = '0;
        for (int b = 0; b < NBLK; b++) begin
            sum = '0;
            for (int p = 0; p < NPLANES; p++) begin
                sum = sum + SUM_W'($countones(map_i[(p*NBLK+b)*NPAGES +: NPAGES]));
            end
            if (b == 0 || sum < best) begin
                best  = sum;
                blk_o = BLK_W'(b);
            end
        end
    end
endmodule

// File: rtl/gc_page_scan.sv
// Finds the lowest valid page at or above a cursor in one plane's block.
// A cursor equal to NPAGES means the plane is exhausted. Combinational.
module gc_page_scan #(
    parameter int NPAGES = 8
) (
    input  logic [NPAGES-1:0]         map_i,
    input  logic [$clog2(NPAGES):0]   cur_i,
    output logic                      hit_o,
    output logic [$clog2(NPAGES)-1:0] page_o
);
    localparam int PG_W  = $clog2(NPAGES);
    localparam int CUR_W = PG_W + 1;

    // Descending scan so the last match taken is the lowest page.
    always_comb begin
        hit_o  = 1'b0;
        page_o = '0;
        for (int g = NPAGES - 1; g >= 0; g--) begin
            if (map_i[g] && (CUR_W'(g) >= cur_i)) begin
                hit_o  = 1'b1;
                page_o = PG_W'(g);
            end
        end
    end
endmodule

// File: rtl/gc_die_seq.sv
// Die-wide garbage collection sequencer. Picks the aligned block group
// with the fewest valid pages, migrates them as paired die reads and
// writes with a shared destination offset, then erases the group once.
// Assumes valid_map_i is stable while busy_o is high.
module gc_die_seq #(
    parameter int NPLANES = 2,
    parameter int NBLK    = 4,
    parameter int NPAGES  = 8
) (
    input  logic                                       clk,
    input  logic                                       rst_n,
    input  logic                                       start_i,
    input  logic [NPLANES*NBLK*NPAGES-1:0]             valid_map_i,
    output logic                                       busy_o,
    output logic                                       done_o,
    output logic                                       cmd_valid_o,
    input  logic                                       cmd_ready_i,
    output logic [1:0]                                 cmd_op_o,
    output logic [$clog2(NBLK)-1:0]                    cmd_blk_o,
    output logic [NPLANES*$clog2(NPAGES)-1:0]          cmd_page_o,
    output logic [NPLANES-1:0]                         cmd_mask_o
);
    import gc_pkg::*;

    localparam int PG_W  = $clog2(NPAGES);
    localparam int BLK_W = $clog2(NBLK);
    localparam int CUR_W = PG_W + 1;

    gc_state_e                        st_q;
    logic [BLK_W-1:0]                 victim_q, pick_blk;
    logic [NPLANES-1:0][CUR_W-1:0]    cur_q;
    logic [NPLANES-1:0][PG_W-1:0]     scan_pg;
    logic [NPLANES-1:0][NPAGES-1:0]   plane_map;
    logic [NPLANES-1:0]               scan_hit, mask_q;
    logic [PG_W-1:0]                  dst_q;
    logic                             fire;

    assign fire = cmd_valid_o && cmd_ready_i;

    gc_victim_pick #(.NPLANES(NPLANES), .NBLK(NBLK), .NPAGES(NPAGES)) u_pick (
        .map_i (valid_map_i),
        .blk_o (pick_blk)
    );

    // One scanner per plane over the victim block's bitmap.
    for (genvar p = 0; p < NPLANES; p++) begin : g_scan
        assign plane_map[p] = valid_map_i[(p*NBLK + int'(victim_q))*NPAGES +: NPAGES];
        gc_page_scan #(.NPAGES(NPAGES)) u_scan (
            .map_i  (plane_map[p]),
            .cur_i  (cur_q[p]),
            .hit_o  (scan_hit[p]),
            .page_o (scan_pg[p])
        );
    end

    // Sequencer state, victim, scan cursors, pair mask and destination offset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= ST_IDLE;
            victim_q <= '0;
            cur_q    <= '0;
            mask_q   <= '0;
            dst_q    <= '0;
        end else begin
            case (st_q)
                ST_IDLE:   if (start_i) st_q <= ST_SELECT;
                ST_SELECT: begin
                    victim_q <= pick_blk;
                    cur_q    <= '0;
                    dst_q    <= '0;
                    st_q     <= ST_READ;
                end
                ST_READ: begin
                    if (!(|scan_hit)) begin
                        st_q <= ST_ERASE;
                    end else if (fire) begin
                        mask_q <= scan_hit;
                        for (int p = 0; p < NPLANES; p++) begin
                            cur_q[p] <= scan_hit[p] ? CUR_W'(scan_pg[p]) + CUR_W'(1)
                                                    : CUR_W'(NPAGES);
                        end
                        st_q <= ST_WRITE;
                    end
                end
                ST_WRITE: if (fire) begin
                    dst_q <= dst_q + PG_W'(1);
                    st_q  <= ST_READ;
                end
                ST_ERASE:  if (fire) st_q <= ST_DONE;
                default:   st_q <= ST_IDLE;
            endcase
        end
    end

    // Status flags from the state.
    always_comb begin
        busy_o = (st_q == ST_SELECT) || (st_q == ST_READ) ||
                 (st_q == ST_WRITE)  || (st_q == ST_ERASE);
        done_o = (st_q == ST_DONE);
    end

    // Command fields for the current state.
    always_comb begin
        cmd_valid_o = 1'b0;
        cmd_op_o    = OP_READ;
        cmd_blk_o   = victim_q;
        cmd_page_o  = '0;
        cmd_mask_o  = '0;
        case (st_q)
            ST_READ: begin
                cmd_valid_o = |scan_hit;
                cmd_mask_o  = scan_hit;
                for (int p = 0; p < NPLANES; p++)
                    cmd_page_o[p*PG_W +: PG_W] = scan_hit[p] ? scan_pg[p] : '0;
            end
            ST_WRITE: begin
                cmd_valid_o = 1'b1;
                cmd_op_o    = OP_WRITE;
                cmd_mask_o  = mask_q;
                for (int p = 0; p < NPLANES; p++)
                    cmd_page_o[p*PG_W +: PG_W] = dst_q;
            end
            ST_ERASE: begin
                cmd_valid_o = 1'b1;
                cmd_op_o    = OP_ERASE;
                cmd_mask_o  = '1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/gc_die_seq_chk.sv
// Protocol checker for gc_die_seq, attached by bind below.
// Observes ports only; assumes synchronous active-low reset.
module gc_die_seq_chk #(
    parameter int NPLANES = 2,
    parameter int NBLK    = 4,
    parameter int NPAGES  = 8
) (
    input logic                              clk,
    input logic                              rst_n,
    input logic                              start_i,
    input logic                              busy_o,
    input logic                              done_o,
    input logic                              cmd_valid_o,
    input logic                              cmd_ready_i,
    input logic [1:0]                        cmd_op_o,
    input logic [$clog2(NBLK)-1:0]           cmd_blk_o,
    input logic [NPLANES*$clog2(NPAGES)-1:0] cmd_page_o,
    input logic [NPLANES-1:0]                cmd_mask_o
);
    // R1: nothing offered while idle
    p_quiet_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !cmd_valid_o);

    // R3: accepted read is followed by its write
    p_read_then_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_o && cmd_ready_i && cmd_op_o == 2'd0) |=> (cmd_valid_o && cmd_op_o == 2'd1));

    // R5: a write always has at least one enabled slot
    p_write_slot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_o && cmd_op_o == 2'd1) |-> (|cmd_mask_o));

    // R7: erase covers every plane
    p_erase_all_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_o && cmd_op_o == 2'd2) |-> (&cmd_mask_o));

    // R8: stalled command holds
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_o && !cmd_ready_i) |=> (cmd_valid_o && $stable(cmd_op_o) &&
        $stable(cmd_blk_o) && $stable(cmd_page_o) && $stable(cmd_mask_o)));

    // R9: accepted erase leads to done with busy dropped
    p_erase_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_o && cmd_ready_i && cmd_op_o == 2'd2) |=> (done_o && !busy_o));

    // R9: done is a single-cycle pulse
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o));

    // R10: start while idle begins a collection
    p_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && !done_o) |=> busy_o);
endmodule

bind gc_die_seq gc_die_seq_chk #(.NPLANES(NPLANES), .NBLK(NBLK), .NPAGES(NPAGES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .cmd_valid_o (cmd_valid_o),
    .cmd_ready_i (cmd_ready_i),
    .cmd_op_o    (cmd_op_o),
    .cmd_blk_o   (cmd_blk_o),
    .cmd_page_o  (cmd_page_o),
    .cmd_mask_o  (cmd_mask_o)
);

// File: tb/test_gc_die_seq.sv
// Self-checking bench for gc_die_seq: directed corners plus seeded
// random bitmaps and random back-pressure, against a bench-side model.
module test_gc_die_seq;
    localparam int NPLANES = 2;
    localparam int NBLK    = 4;
    localparam int NPAGES  = 8;
    localparam int PG_W    = $clog2(NPAGES);
    localparam int BLK_W   = $clog2(NBLK);
    localparam int MAP_W   = NPLANES*NBLK*NPAGES;
    localparam int MAXC    = 2*NPAGES + 1;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    start_i = 1'b0;
    logic [MAP_W-1:0]        valid_map_i = '0;
    logic                    busy_o, done_o, cmd_valid_o;
    logic                    cmd_ready_i = 1'b0;
    logic [1:0]              cmd_op_o;
    logic [BLK_W-1:0]        cmd_blk_o;
    logic [NPLANES*PG_W-1:0] cmd_page_o;
    logic [NPLANES-1:0]      cmd_mask_o;

    gc_die_seq #(.NPLANES(NPLANES), .NBLK(NBLK), .NPAGES(NPAGES)) i_gc_die_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .valid_map_i(valid_map_i),
        .busy_o(busy_o), .done_o(done_o), .cmd_valid_o(cmd_valid_o),
        .cmd_ready_i(cmd_ready_i), .cmd_op_o(cmd_op_o), .cmd_blk_o(cmd_blk_o),
        .cmd_page_o(cmd_page_o), .cmd_mask_o(cmd_mask_o)
    );

    always #2 clk = ~clk;   // 250 MHz

    int checks = 0;
    int errors = 0;
    bit rand_ready = 1'b0;

    int                      exp_n;
    int                      exp_blk;
    int                      exp_op   [MAXC];
    logic [NPLANES*PG_W-1:0] exp_page [MAXC];
    logic [NPLANES-1:0]      exp_mask [MAXC];

    int  got_k = 0;
    int  done_cnt = 0;
    bit  running = 1'b0;
    bit  erase_seen = 1'b0;
    bit  prev_stall = 1'b0;
    logic [1:0]              prev_op;
    logic [BLK_W-1:0]        prev_blk;
    logic [NPLANES*PG_W-1:0] prev_page;
    logic [NPLANES-1:0]      prev_mask;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    // Model of R2..R7: expected command list for a bitmap.
    task automatic build_exp(input logic [MAP_W-1:0] m);
        int best, vb, npair;
        int cnt [NPLANES];
        int lst [NPLANES][NPAGES];
        best = 0; vb = 0;
        for (int b = 0; b < NBLK; b++) begin
            int s = 0;
            for (int p = 0; p < NPLANES; p++)
                for (int g = 0; g < NPAGES; g++)
                    s += int'(m[(p*NBLK+b)*NPAGES+g]);
            if (b == 0 || s < best) begin best = s; vb = b; end
        end
        exp_blk = vb;
        npair = 0;
        for (int p = 0; p < NPLANES; p++) begin
            cnt[p] = 0;
            for (int g = 0; g < NPAGES; g++)
                if (m[(p*NBLK+vb)*NPAGES+g]) begin lst[p][cnt[p]] = g; cnt[p]++; end
            if (cnt[p] > npair) npair = cnt[p];
        end
        exp_n = 0;
        for (int i = 0; i < npair; i++) begin
            logic [NPLANES-1:0]      mk = '0;
            logic [NPLANES*PG_W-1:0] pg = '0, dp = '0;
            for (int p = 0; p < NPLANES; p++) begin
                if (i < cnt[p]) begin mk[p] = 1'b1; pg[p*PG_W +: PG_W] = PG_W'(lst[p][i]); end
                dp[p*PG_W +: PG_W] = PG_W'(i);
            end
            exp_op[exp_n] = 0; exp_mask[exp_n] = mk; exp_page[exp_n] = pg; exp_n++;
            exp_op[exp_n] = 1; exp_mask[exp_n] = mk; exp_page[exp_n] = dp; exp_n++;
        end
        exp_op[exp_n] = 2; exp_mask[exp_n] = '1; exp_page[exp_n] = '0; exp_n++;
    endtask

    // Back-pressure driver, changes inputs just after each rising edge.
    initial forever begin
        @(posedge clk);
        #1;
        cmd_ready_i = rand_ready ? ($urandom_range(0, 3) != 0) : 1'b1;
    end

    // Port monitor at the falling edge: compare accepted commands to the model.
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_stall) begin
                chk(cmd_valid_o == 1'b1, "R8", "stalled valid", int'(cmd_valid_o), 1);
                chk({cmd_op_o, cmd_blk_o, cmd_page_o, cmd_mask_o} ==
                    {prev_op, prev_blk, prev_page, prev_mask}, "R8", "stalled fields",
                    int'(cmd_page_o), int'(prev_page));
            end
            prev_stall = cmd_valid_o && !cmd_ready_i;
            prev_op = cmd_op_o; prev_blk = cmd_blk_o;
            prev_page = cmd_page_o; prev_mask = cmd_mask_o;
            if (running && !erase_seen)
                chk(busy_o == 1'b1, "R9", "busy during run", int'(busy_o), 1);
            if (!busy_o)
                chk(cmd_valid_o == 1'b0, "R1", "valid while idle", int'(cmd_valid_o), 0);
            if (done_o) begin
                done_cnt++;
                chk(erase_seen && got_k == exp_n, "R3", "commands before done", got_k, exp_n);
                chk(busy_o == 1'b0, "R9", "busy with done", int'(busy_o), 0);
            end
            if (cmd_valid_o && cmd_ready_i) begin
                if (!running || got_k >= exp_n) begin
                    chk(1'b0, "R10", "unexpected command", got_k, exp_n);
                end else begin
                    chk(int'(cmd_op_o) == exp_op[got_k], "R3", "opcode", int'(cmd_op_o), exp_op[got_k]);
                    chk(int'(cmd_blk_o) == exp_blk, "R2", "victim", int'(cmd_blk_o), exp_blk);
                    chk(cmd_mask_o == exp_mask[got_k], (exp_op[got_k] == 2) ? "R7" : "R4",
                        "mask", int'(cmd_mask_o), int'(exp_mask[got_k]));
                    chk(cmd_page_o == exp_page[got_k], (exp_op[got_k] == 1) ? "R5" : "R4",
                        "page", int'(cmd_page_o), int'(exp_page[got_k]));
                    if (exp_op[got_k] == 2) erase_seen = 1'b1;
                    got_k++;
                end
            end
        end
    end

    // One collection: start, optional extra start while busy, wait for done.
    task automatic run_case(input logic [MAP_W-1:0] m, input bit extra_start);
        int waited;
        valid_map_i = m;
        build_exp(m);
        got_k = 0; done_cnt = 0; erase_seen = 1'b0;
        @(posedge clk); #1; start_i = 1'b1;
        @(posedge clk); #1; start_i = 1'b0; running = 1'b1;
        if (extra_start) begin
            @(posedge clk); #1; start_i = 1'b1;   // R10: sampled while busy
            @(posedge clk); #1; start_i = 1'b0;
        end
        waited = 0;
        while (done_cnt == 0 && waited < 2000) begin
            @(negedge clk);
            waited++;
        end
        chk(done_cnt == 1, "R9", "done pulse seen", done_cnt, 1);
        chk(got_k == exp_n, "R6", "command count", got_k, exp_n);
        running = 1'b0;
        repeat (3) @(negedge clk);
        chk(busy_o == 1'b0 && cmd_valid_o == 1'b0, "R10", "quiet after done",
            int'(busy_o) + int'(cmd_valid_o), 0);
        chk(done_cnt == 1, "R9", "single done pulse", done_cnt, 1);
    endtask

    // Watchdog: a hung run is a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        summary();
        $finish;
    end

    initial begin
        logic [MAP_W-1:0] m;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(busy_o == 1'b0, "R1", "reset busy", int'(busy_o), 0);
        chk(done_o == 1'b0, "R1", "reset done", int'(done_o), 0);
        chk(cmd_valid_o == 1'b0, "R1", "reset valid", int'(cmd_valid_o), 0);

        // R6: empty die, every sum ties at zero, straight to erase on block 0.
        run_case('0, 1'b0);

        // R2: blocks 1 and 2 tie at the minimum, lowest wins.
        m = '1;
        m[(0*NBLK+1)*NPAGES +: NPAGES] = 8'b0000_0101;
        m[(1*NBLK+1)*NPAGES +: NPAGES] = 8'b0000_0000;
        m[(0*NBLK+2)*NPAGES +: NPAGES] = 8'b0000_0000;
        m[(1*NBLK+2)*NPAGES +: NPAGES] = 8'b1000_0001;
        run_case(m, 1'b0);

        // R4/R5: unequal planes, the short plane padded.
        m = '1;
        m[(0*NBLK+3)*NPAGES +: NPAGES] = 8'b1010_0010;
        m[(1*NBLK+3)*NPAGES +: NPAGES] = 8'b0100_0000;
        run_case(m, 1'b1);

        // R6: full die, block 0 wins, maximum pair count.
        rand_ready = 1'b1;
        run_case('1, 1'b0);

        // Random bitmaps with back-pressure and occasional start while busy.
        for (int t = 0; t < 40; t++) begin
            m = {$urandom, $urandom};
            if (t % 3 == 0) m = m & {$urandom, $urandom};
            if (t % 5 == 1) m = m | {$urandom, $urandom};
            run_case(m, (t % 4) == 2);
        end

        summary();
        $finish;
    end
endmodule